// File: doc/BRIEF.md
# Interrupt Line Mapper and Single-Request Poster

This block watches 64 level-sensitive interrupt lines and turns them into at most one outstanding interrupt-vector request. Lines 0 to 31 belong to expansion-bus slots and are gated in groups of four. Lines 32 to 63 belong to on-board devices and are gated one at a time. Software sets a gate by writing the top bit of a mapping register. It acknowledges the posted request by writing to a clear location, or by closing the gate that owns the request.

The posted request is shown as a line number, a valid flag and a one-hot vector. It stays in place until software removes it. A slot line that rises while its gate is open takes over at once, even when another request is already posted. An on-board line that rises is posted only when nothing is posted. In the cycle after any acknowledge, the block looks again at all lines that are still asserted and have an open gate. It posts the lowest-numbered one, so slot lines come before on-board lines.

Top module: `irq_map_ctrl`

## Requirements
- R1: After reset, no request is posted: `req_valid`=0, `req_num`=64 (the reserved "none" value) and `req_onehot`=0. Every gate is closed, so reading slot group register g returns 0x7C0|(g<<2) and reading on-board register i returns 0x7E0+i, both with bit 31 clear.
- R2: The slot group register g sits at byte offsets 0x0C00–0x0C3F, with index (offset>>3)&7. The on-board register i sits at 0x1000–0x1080, with index (offset>>3)&31. A write changes only bit 31, the gate. A read returns the fixed low bits with the gate in bit 31. A read of any other offset returns 0.
- R3: If one or more slot lines rise while their group gate is open, the lowest such line is posted on the next clock edge. This replaces any request already posted.
- R4: A line whose gate is closed never becomes posted. Opening the gate while the line is already high does not post it.
- R5: A rising on-board line with an open gate is posted on the next edge only if no request is posted. Otherwise the rising edge does not change the posted request.
- R6: A posted request keeps the same number until it is acknowledged or a slot line takes over.
- R7: A mapping write with bit 31 clear removes the posted request if that request belongs to the entry being written (the group for slot lines, the line for on-board lines). A write with bit 31 set, or a write to another entry, leaves the request in place.
- R8: A write to offsets 0x1400–0x14FF acknowledges group (offset>>5)&7. It removes the posted request only if that request is a slot line in that group.
- R9: A write to offsets 0x1800–0x1860 acknowledges line 32+((offset>>3)&31). It removes the posted request only if that line is the one posted.
- R10: On the edge after a removal, the lowest-numbered line that is asserted and has an open gate is posted. If there is none, nothing is posted.
- R11: `req_onehot` has exactly the bit `req_num` set when `req_valid` is 1, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 64 | Interrupt lines; 0–31 slot, 32–63 on-board |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 16 | Write byte offset |
| wr_data | input | 32 | Write data; bit 31 is the gate |
| rd_addr | input | 16 | Read byte offset |
| rd_data | output | 32 | Combinational read data |
| req_valid | output | 1 | A request is posted |
| req_num | output | 7 | Posted line number, 64 when none |
| req_onehot | output | 64 | Posted line as a one-hot vector |

## Verification
The assertions check four rules on every cycle:
- the one-hot vector always agrees with the number;
- a posted line always has an open gate;
- a posted request holds while no removal or slot takeover occurs, and is gone after a removal;
- nothing appears while the block is idle and has no rising line.

Only the bench scenarios can show the rest: which line wins among several, that the decoded offsets reach the right group or line, that mismatched acknowledges do nothing, and what the post-removal rescan selects. The bench sweeps every slot line and every reachable on-board register to cover these.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int PCI_GRPS  = 8;
  localparam int GRP_SIZE  = 4;
  localparam int OBD_LINES = 32;
  localparam int PCI_LINES = PCI_GRPS * GRP_SIZE;
  localparam int LINES     = PCI_LINES + OBD_LINES;
  localparam int NUM_W     = $clog2(LINES) + 1;
  localparam int GW        = $clog2(PCI_GRPS);
  localparam int OW        = $clog2(OBD_LINES);
  localparam logic [NUM_W-1:0] NO_REQ = NUM_W'(LINES);

  localparam logic [15:0] PCI_MAP_LO = 16'h0C00;
  localparam logic [15:0] PCI_MAP_HI = 16'h0C3F;
  localparam logic [15:0] OBD_MAP_LO = 16'h1000;
  localparam logic [15:0] OBD_MAP_HI = 16'h1080;
  localparam logic [15:0] PCI_ACK_LO = 16'h1400;
  localparam logic [15:0] PCI_ACK_HI = 16'h14FF;
  localparam logic [15:0] OBD_ACK_LO = 16'h1800;
  localparam logic [15:0] OBD_ACK_HI = 16'h1860;

  function automatic logic [31:0] pci_map_init(int g);
    return 32'h0000_07C0 | (32'(g) << 2);
  endfunction

  function automatic logic [31:0] obd_map_init(int i);
    return 32'h0000_07E0 + 32'(i);
  endfunction

  function automatic logic [NUM_W-1:0] lowest_set(logic [LINES-1:0] v);
    logic [NUM_W-1:0] r;
    r = NO_REQ;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (v[i]) r = NUM_W'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/irqc_edge.sv
module irqc_edge
  import irqc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] irq_in,
  output logic [LINES-1:0] rise,
  output logic [LINES-1:0] level
);
  logic [LINES-1:0] latch_q;

  always_ff @(posedge clk) begin
    if (!rst_n) latch_q <= '0;
    else        latch_q <= irq_in;
  end

  assign rise  = irq_in & ~latch_q;
  assign level = latch_q;
endmodule

// File: rtl/irqc_regfile.sv
module irqc_regfile
  import irqc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [15:0]      wr_addr,
  input  logic             wr_gate,
  input  logic [15:0]      rd_addr,
  output logic [31:0]      rd_data,
  output logic [LINES-1:0] en_mask,
  output logic             pci_drop_v,
  output logic [GW-1:0]    pci_drop_grp,
  output logic             obd_drop_v,
  output logic [OW-1:0]    obd_drop_idx
);
  logic [PCI_GRPS-1:0]  pci_en;
  logic [OBD_LINES-1:0] obd_en;

  logic pci_map_wr, obd_map_wr, pci_ack_wr, obd_ack_wr;
  logic [GW-1:0] pci_wr_idx, pci_rd_idx;
  logic [OW-1:0] obd_wr_idx, obd_rd_idx;

  assign pci_map_wr = wr_en && wr_addr >= PCI_MAP_LO && wr_addr <= PCI_MAP_HI;
  assign obd_map_wr = wr_en && wr_addr >= OBD_MAP_LO && wr_addr <= OBD_MAP_HI;
  assign pci_ack_wr = wr_en && wr_addr >= PCI_ACK_LO && wr_addr <= PCI_ACK_HI;
  assign obd_ack_wr = wr_en && wr_addr >= OBD_ACK_LO && wr_addr <= OBD_ACK_HI;

  assign pci_wr_idx = wr_addr[GW+2:3];
  assign obd_wr_idx = wr_addr[OW+2:3];
  assign pci_rd_idx = rd_addr[GW+2:3];
  assign obd_rd_idx = rd_addr[OW+2:3];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pci_en <= '0;
      obd_en <= '0;
    end else begin
      if (pci_map_wr) pci_en[pci_wr_idx] <= wr_gate;
      if (obd_map_wr) obd_en[obd_wr_idx] <= wr_gate;
    end
  end

  // Removal requests; matching against the posted line happens downstream.
  assign pci_drop_v   = (pci_map_wr && !wr_gate) || pci_ack_wr;
  assign pci_drop_grp = pci_map_wr ? pci_wr_idx : wr_addr[GW+4:5];
  assign obd_drop_v   = (obd_map_wr && !wr_gate) || obd_ack_wr;
  assign obd_drop_idx = obd_wr_idx;

  for (genvar l = 0; l < LINES; l++) begin : g_mask
    if (l < PCI_LINES) begin : g_pci
      assign en_mask[l] = pci_en[l / GRP_SIZE];
    end else begin : g_obd
      assign en_mask[l] = obd_en[l - PCI_LINES];
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr >= PCI_MAP_LO && rd_addr <= PCI_MAP_HI)
      rd_data = pci_map_init(int'(pci_rd_idx)) | {pci_en[pci_rd_idx], 31'b0};
    else if (rd_addr >= OBD_MAP_LO && rd_addr <= OBD_MAP_HI)
      rd_data = obd_map_init(int'(obd_rd_idx)) | {obd_en[obd_rd_idx], 31'b0};
  end

  p_one_write_kind_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({pci_map_wr, obd_map_wr, pci_ack_wr, obd_ack_wr}) <= 1);
endmodule

// File: rtl/irqc_pending.sv
module irqc_pending
  import irqc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] rise,
  input  logic [LINES-1:0] level,
  input  logic [LINES-1:0] en_mask,
  input  logic             pci_drop_v,
  input  logic [GW-1:0]    pci_drop_grp,
  input  logic             obd_drop_v,
  input  logic [OW-1:0]    obd_drop_idx,
  output logic [NUM_W-1:0] pend_num,
  output logic             pend_valid
);
  localparam logic [LINES-1:0] PCI_SIDE = {{OBD_LINES{1'b0}}, {PCI_LINES{1'b1}}};

  logic [NUM_W-1:0] pend_q;
  logic             rescan_q;
  logic [LINES-1:0] pci_new, obd_new, cand;
  logic             pci_post, clr_hit, pend_is_pci;
  logic [GW-1:0]    pend_grp;
  logic [OW-1:0]    pend_obd;

  assign pend_valid  = (pend_q != NO_REQ);
  assign pend_is_pci = (pend_q < NUM_W'(PCI_LINES));
  assign pend_grp    = GW'(pend_q / NUM_W'(GRP_SIZE));
  assign pend_obd    = OW'(pend_q - NUM_W'(PCI_LINES));

  assign pci_new  = rise & en_mask & PCI_SIDE;
  assign obd_new  = rise & en_mask & ~PCI_SIDE;
  assign pci_post = |pci_new;
  assign clr_hit  = pend_valid &&
                    ((pci_drop_v && pend_is_pci && pend_grp == pci_drop_grp) ||
                     (obd_drop_v && !pend_is_pci && pend_obd == obd_drop_idx));
  assign cand     = (rescan_q ? (level & en_mask) : '0) | obd_new;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q   <= NO_REQ;
      rescan_q <= 1'b0;
    end else if (pci_post) begin
      pend_q   <= lowest_set(pci_new);
      rescan_q <= 1'b0;
    end else if (clr_hit) begin
      pend_q   <= NO_REQ;
      rescan_q <= 1'b1;
    end else begin
      if (!pend_valid && |cand) pend_q <= lowest_set(cand);
      rescan_q <= 1'b0;
    end
  end

  assign pend_num = pend_q;

  p_gate_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pend_valid |-> en_mask[pend_q[NUM_W-2:0]]);
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pend_valid && !clr_hit && !pci_post |=> $stable(pend_q));
  p_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_hit && !pci_post |=> !pend_valid);
  p_pci_takes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pci_post |=> pend_valid && pend_is_pci);
  p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_valid && !rescan_q && !pci_post && !(|obd_new) |=> !pend_valid);
endmodule

// File: rtl/irq_map_ctrl.sv
module irq_map_ctrl
  import irqc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] irq_in,
  input  logic             wr_en,
  input  logic [15:0]      wr_addr,
  input  logic [31:0]      wr_data,
  input  logic [15:0]      rd_addr,
  output logic [31:0]      rd_data,
  output logic             req_valid,
  output logic [NUM_W-1:0] req_num,
  output logic [LINES-1:0] req_onehot
);
  logic [LINES-1:0] rise, level, en_mask;
  logic             pci_drop_v, obd_drop_v;
  logic [GW-1:0]    pci_drop_grp;
  logic [OW-1:0]    obd_drop_idx;
  logic [30:0]      unused_wr_low;

  assign unused_wr_low = wr_data[30:0];

  irqc_edge u_edge (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .rise(rise), .level(level)
  );

  irqc_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_gate(wr_data[31]), .rd_addr(rd_addr), .rd_data(rd_data),
    .en_mask(en_mask), .pci_drop_v(pci_drop_v), .pci_drop_grp(pci_drop_grp),
    .obd_drop_v(obd_drop_v), .obd_drop_idx(obd_drop_idx)
  );

  irqc_pending u_pend (
    .clk(clk), .rst_n(rst_n), .rise(rise), .level(level), .en_mask(en_mask),
    .pci_drop_v(pci_drop_v), .pci_drop_grp(pci_drop_grp),
    .obd_drop_v(obd_drop_v), .obd_drop_idx(obd_drop_idx),
    .pend_num(req_num), .pend_valid(req_valid)
  );

  for (genvar l = 0; l < LINES; l++) begin : g_onehot
    assign req_onehot[l] = req_valid && (req_num == NUM_W'(l));
  end

  p_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_onehot) && (req_valid == (|req_onehot)));
  p_none_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> req_num == NO_REQ);
endmodule

// File: tb/tb_irq_map_ctrl.sv
module tb_irq_map_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] irq = '0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [15:0] rd_addr = '0;
  logic [31:0] rd_data;
  logic        req_valid;
  logic [6:0]  req_num;
  logic [63:0] req_onehot;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  irq_map_ctrl dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .req_valid(req_valid), .req_num(req_num), .req_onehot(req_onehot)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  // expected posted line, 64 meaning none
  task automatic chk_req(input string r, input int e);
    logic [63:0] oh;
    oh = (e < 64) ? (64'd1 << e) : 64'd0;
    chk(r, {req_valid, req_num, req_onehot}, {(e < 64) ? 1'b1 : 1'b0, 7'(e), oh});
  endtask

  task automatic chk_rd(input string r, input logic [15:0] a, input logic [31:0] e);
    rd_addr = a;
    #1;
    chk(r, 64'(rd_data), 64'(e));
  endtask

  function automatic logic [31:0] pci_exp(int g);
    return 32'h7C0 + 32'(4 * g);
  endfunction

  function automatic logic [31:0] obd_exp(int i);
    return 32'h7E0 + 32'(i);
  endfunction

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    step();

    // R1 reset state
    chk_req("R1", 64);
    for (int g = 0; g < 8; g++) chk_rd("R1", 16'h0C00 + 16'(8 * g), pci_exp(g));
    for (int i = 0; i < 17; i++) chk_rd("R1", 16'h1000 + 16'(8 * i), obd_exp(i));

    // R2 readback: only bit 31 sticks
    for (int g = 0; g < 8; g++) begin
      wr(16'h0C00 + 16'(8 * g), 32'hFFFF_FFFF);
      chk_rd("R2", 16'h0C04 + 16'(8 * g), pci_exp(g) | 32'h8000_0000);
      wr(16'h0C00 + 16'(8 * g), 32'h0000_1234);
      chk_rd("R2", 16'h0C00 + 16'(8 * g), pci_exp(g));
    end
    for (int i = 0; i < 17; i++) begin
      wr(16'h1000 + 16'(8 * i), 32'hFFFF_FFFF);
      chk_rd("R2", 16'h1000 + 16'(8 * i), obd_exp(i) | 32'h8000_0000);
      wr(16'h1000 + 16'(8 * i), 32'h7FFF_FFFF);
      chk_rd("R2", 16'h1000 + 16'(8 * i), obd_exp(i));
    end
    chk_rd("R2", 16'h2000, 32'h0);

    // R4 closed gate ignores the line, late opening does not post
    irq[5] = 1'b1; step();
    chk_req("R4", 64);
    wr(16'h0C08, 32'h8000_0000);
    chk_req("R4", 64);
    step(); chk_req("R4", 64);
    irq[5] = 1'b0; step();
    wr(16'h0C08, 32'h0);

    // R3/R8 sweep over every slot line
    for (int l = 0; l < 32; l++) begin
      int g;
      g = l / 4;
      wr(16'h0C00 + 16'(8 * g), 32'h8000_0000);
      irq[l] = 1'b1; step();
      chk_req("R3", l);
      wr(16'h1400 + 16'(32 * ((g + 1) % 8)), 32'h0);
      chk_req("R8", l);
      irq[l] = 1'b0; step();
      wr(16'h1400 + 16'(32 * g) + 16'(l % 4), 32'h0);
      chk_req("R8", 64);
      step(); chk_req("R10", 64);
      wr(16'h0C00 + 16'(8 * g), 32'h0);
    end

    // R9/R7 sweep over reachable on-board registers
    for (int i = 0; i < 17; i++) begin
      wr(16'h1000 + 16'(8 * i), 32'h8000_0000);
      irq[32 + i] = 1'b1; step();
      chk_req("R5", 32 + i);
      irq[32 + i] = 1'b0; step();
      if (i <= 12) begin
        wr(16'h1800 + 16'(8 * ((i + 1) % 13)), 32'h0);
        chk_req("R9", 32 + i);
        wr(16'h1800 + 16'(8 * i), 32'h0);
        chk_req("R9", 64);
      end else begin
        wr(16'h1000 + 16'(8 * i), 32'h0);
        chk_req("R7", 64);
      end
      step(); chk_req("R10", 64);
      wr(16'h1000 + 16'(8 * i), 32'h0);
    end

    // R3 takeover and R10 rescan order
    for (int g = 0; g < 8; g++) wr(16'h0C00 + 16'(8 * g), 32'h8000_0000);
    irq[10] = 1'b1; step(); chk_req("R3", 10);
    irq[3]  = 1'b1; step(); chk_req("R3", 3);
    irq[20] = 1'b1; irq[7] = 1'b1; step(); chk_req("R3", 7);
    chk_req("R6", 7);
    wr(16'h1420, 32'h0); chk_req("R8", 64);
    step(); chk_req("R10", 3);
    wr(16'h0C00, 32'h0); chk_req("R7", 64);
    step(); chk_req("R10", 7);
    irq = '0; step();
    wr(16'h1420, 32'h0); chk_req("R8", 64);
    step(); chk_req("R10", 64);
    for (int g = 0; g < 8; g++) wr(16'h0C00 + 16'(8 * g), 32'h0);

    // R5 on-board does not displace, R10/R7 on on-board lines
    wr(16'h1008, 32'h8000_0000);
    wr(16'h1040, 32'h8000_0000);
    wr(16'h0C00, 32'h8000_0000);
    irq[33] = 1'b1; step(); chk_req("R5", 33);
    irq[40] = 1'b1; step(); chk_req("R5", 33);
    step(); chk_req("R6", 33);
    wr(16'h1800, 32'h0); chk_req("R9", 33);
    irq[33] = 1'b0; step();
    wr(16'h1808, 32'h0); chk_req("R9", 64);
    step(); chk_req("R10", 40);
    wr(16'h1040, 32'h0); chk_req("R7", 64);
    step(); chk_req("R10", 64);
    wr(16'h1040, 32'h8000_0000); chk_req("R4", 64);
    step(); chk_req("R4", 64);
    irq[40] = 1'b0; step();
    irq[40] = 1'b1; step(); chk_req("R5", 40);
    irq[2] = 1'b1; step(); chk_req("R3", 2);
    wr(16'h1400, 32'h0); chk_req("R8", 64);
    step(); chk_req("R10", 2);
    irq[2] = 1'b0; step();
    wr(16'h1400, 32'h0); chk_req("R8", 64);
    step(); chk_req("R10", 40);
    wr(16'h1040, 32'h8000_0000); chk_req("R7", 40);
    wr(16'h0C00, 32'h0); chk_req("R7", 40);
    irq = '0; step();
    wr(16'h1040, 32'h0); chk_req("R7", 64);
    step(); chk_req("R11", 64);

    done = 1;
    summary();
    $finish;
  end
endmodule